// File: doc/BRIEF.md
# Guarded Clock Source Control Register

This block is a single byte-wide control register on the system bus. It chooses which source feeds the base clock and holds the enables for the main PLL and the subclock path. Its outputs drive an external clock multiplexer and PLL. The multiplexer, PLL, oscillators and gear sequencer are outside the block.

Certain changes are unsafe while the clock tree is in a given state, and the register guards against them. A bus write is split into fields. Each field that would change illegally keeps its old value, while the legal fields of the same write still take effect. Any rejected field raises a one-cycle protection-violation flag. A synchronous reset request either clears the control bits or leaves the whole register as it is, according to a reset-kind input. The PLL enable output is also forced low while the main oscillator is halted in stop mode.

Top module: `clksrc_guard_reg`

## Requirements
- R1: `bus_hit` is 1 exactly when `bus_addr` equals 0x0484. In that same cycle `bus_rdata` shows the stored byte. With any other address, `bus_rdata` is 0.
- R2: A write is `bus_we`=1 together with `bus_hit`=1 and no reset request. It takes effect on the next rising clock edge. Bits 7..4 store whatever value was written and read back unchanged.
- R3: `rst_n` low clears all eight bits asynchronously. A cycle with `rst_req`=1 and `rst_soft`=0 clears bits 3..0 and keeps bits 7..4. A cycle with `rst_req`=1 and `rst_soft`=1 leaves all bits unchanged. A reset request overrides a write in the same cycle.
- R4: Bit 3 (subclock enable) does not change through a write while the source field holds 11.
- R5: Bit 2 (PLL enable) does not change through a write while the source field holds 10, or while `gear_busy` is 1.
- R6: Bits 1..0 form the source field. While bit 1 is 1, a write that would change bit 0 is rejected, and both source bits keep their values.
- R7: A write of source code 11 is rejected if the resulting bit 3 is 0. A write of code 10 is rejected if the resulting bit 2 is 0. Codes 00 and 01 both select the main oscillator divided by 2; a write of either is not rejected by this rule.
- R8: `src_sel` shows bits 1..0 and `subclk_en` shows bit 3. `pll_run` equals bit 2, except that it is 0 whenever `osc_halted` and `stop_mode` are both 1.
- R9: `prot_err` pulses for one cycle, in the cycle after a write in which any field was rejected. It is 0 at all other times. The legal fields of a rejected write are still stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| rst_req | input | 1 | Synchronous reset request |
| rst_soft | input | 1 | Reset kind: 1 = software (hold), 0 = pin or watchdog (clear) |
| bus_addr | input | 16 | Byte address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational |
| bus_hit | output | 1 | Address match |
| gear_busy | input | 1 | Gear-up/down in progress |
| osc_halted | input | 1 | Main oscillator halted |
| stop_mode | input | 1 | Device in stop mode |
| src_sel | output | 2 | Source select to the clock multiplexer |
| subclk_en | output | 1 | Subclock path enable |
| pll_run | output | 1 | PLL run enable after gating |
| prot_err | output | 1 | Protection-violation pulse |

## Verification
A corrupted stored byte shows on `bus_rdata` at the next matching read, and on `src_sel` and `subclk_en` at once. A filter that lets an illegal change through leaves the source field at 11 with bit 3 clear, or at 10 with bit 2 clear. Such a state is visible in the first cycle after the edge, and `prot_err` is missing in that same cycle. A gating fault shows on `pll_run` in the same cycle that the stop-mode inputs change.

// File: rtl/clkguard_pkg.sv
package clkguard_pkg;

    localparam int REG_W  = 8;
    localparam int RSVD_W = 4;

    typedef enum logic [1:0] {
        SRC_OSC_A = 2'b00,
        SRC_OSC_B = 2'b01,
        SRC_PLL   = 2'b10,
        SRC_SUB   = 2'b11
    } src_e;

    typedef struct packed {
        logic [RSVD_W-1:0] rsvd;
        logic              sub_en;
        logic              pll_en;
        src_e              src;
    } ctl_t;

    typedef struct packed {
        ctl_t ctl;
        logic err;
    } state_t;

endpackage

// File: rtl/clkguard_decode.sv
module clkguard_decode #(
    parameter int              ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] REG_ADDR = 16'h0484
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit
);
    always_comb begin
        hit = (addr == REG_ADDR);
    end
endmodule

// File: rtl/clkguard_wrfilt.sv
module clkguard_wrfilt
    import clkguard_pkg::*;
(
    input  ctl_t             cur,
    input  logic [REG_W-1:0] wdata,
    input  logic             gear_busy,
    output ctl_t             nxt,
    output logic             reject
);
    ctl_t req;
    logic sub_lock, pll_lock, sub_bad, pll_bad, sel_bad;
    logic sel0_lock, need_sub, need_pll;

    always_comb begin
        req      = ctl_t'(wdata);
        sub_lock = (cur.src == SRC_SUB);
        pll_lock = (cur.src == SRC_PLL) || gear_busy;

        nxt      = cur;
        nxt.rsvd = req.rsvd;

        sub_bad    = sub_lock && (req.sub_en != cur.sub_en);
        nxt.sub_en = sub_lock ? cur.sub_en : req.sub_en;

        pll_bad    = pll_lock && (req.pll_en != cur.pll_en);
        nxt.pll_en = pll_lock ? cur.pll_en : req.pll_en;

        sel0_lock = cur.src[1] && (req.src[0] != cur.src[0]);
        need_sub  = (req.src == SRC_SUB) && !nxt.sub_en;
        need_pll  = (req.src == SRC_PLL) && !nxt.pll_en;
        sel_bad   = sel0_lock || need_sub || need_pll;
        nxt.src   = sel_bad ? cur.src : req.src;

        reject = sub_bad || pll_bad || sel_bad;
    end
endmodule

// File: rtl/clkguard_pllgate.sv
module clkguard_pllgate (
    input  logic pll_bit,
    input  logic osc_halted,
    input  logic stop_mode,
    output logic pll_run
);
    always_comb begin
        pll_run = pll_bit && !(osc_halted && stop_mode);
    end
endmodule

// File: rtl/clksrc_guard_reg.sv
module clksrc_guard_reg
    import clkguard_pkg::*;
#(
    parameter int                ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] REG_ADDR = 16'h0484
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rst_req,
    input  logic              rst_soft,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    output logic              bus_hit,
    input  logic              gear_busy,
    input  logic              osc_halted,
    input  logic              stop_mode,
    output logic [1:0]        src_sel,
    output logic              subclk_en,
    output logic              pll_run,
    output logic              prot_err
);
    state_t st_d, st_q;
    ctl_t   filt_nxt;
    logic   filt_rej;
    logic   hit;

    clkguard_decode #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_dec (
        .addr (bus_addr),
        .hit  (hit)
    );

    clkguard_wrfilt u_filt (
        .cur       (st_q.ctl),
        .wdata     (bus_wdata),
        .gear_busy (gear_busy),
        .nxt       (filt_nxt),
        .reject    (filt_rej)
    );

    clkguard_pllgate u_gate (
        .pll_bit    (st_q.ctl.pll_en),
        .osc_halted (osc_halted),
        .stop_mode  (stop_mode),
        .pll_run    (pll_run)
    );

    always_comb begin
        st_d     = st_q;
        st_d.err = 1'b0;
        if (rst_req) begin
            if (!rst_soft) begin
                st_d.ctl.sub_en = 1'b0;
                st_d.ctl.pll_en = 1'b0;
                st_d.ctl.src    = SRC_OSC_A;
            end
        end else if (bus_we && hit) begin
            st_d.ctl = filt_nxt;
            st_d.err = filt_rej;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        bus_hit   = hit;
        bus_rdata = hit ? REG_W'(st_q.ctl) : '0;
        src_sel   = st_q.ctl.src;
        subclk_en = st_q.ctl.sub_en;
        prot_err  = st_q.err;
    end
endmodule

// File: rtl/clkguard_chk.sv
module clkguard_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       rst_req,
    input logic       rst_soft,
    input logic       bus_we,
    input logic       bus_hit,
    input logic       gear_busy,
    input logic       osc_halted,
    input logic       stop_mode,
    input logic [7:0] ctl,
    input logic       prot_err,
    input logic       pll_run
);
    AST_SOFT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_req && rst_soft) |=> (ctl == $past(ctl))); // R3
    AST_HARD_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_req && !rst_soft) |=> (ctl[3:0] == 4'h0 && ctl[7:4] == $past(ctl[7:4]))); // R3
    AST_SUB_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl[1:0] == 2'b11 && !rst_req) |=> (ctl[3] == $past(ctl[3]))); // R4
    AST_PLL_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        ((ctl[1:0] == 2'b10 || gear_busy) && !rst_req) |=> (ctl[2] == $past(ctl[2]))); // R5
    AST_SEL0_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl[1] && !rst_req) |=> (ctl[0] == $past(ctl[0]))); // R6
    AST_SUB_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl[1:0] == 2'b11) |-> ctl[3]); // R7
    AST_PLL_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl[1:0] == 2'b10) |-> ctl[2]); // R7
    AST_PLL_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (osc_halted && stop_mode) |-> !pll_run); // R8
    AST_ERR_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        prot_err |-> $past(bus_we && bus_hit && !rst_req)); // R9
endmodule

bind clksrc_guard_reg clkguard_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_req    (rst_req),
    .rst_soft   (rst_soft),
    .bus_we     (bus_we),
    .bus_hit    (bus_hit),
    .gear_busy  (gear_busy),
    .osc_halted (osc_halted),
    .stop_mode  (stop_mode),
    .ctl        (st_q.ctl),
    .prot_err   (prot_err),
    .pll_run    (pll_run)
);

// File: tb/sim_clksrc_guard_reg.sv
module sim_clksrc_guard_reg;
    localparam int CLK_PER = 10;
    localparam logic [15:0] ADR = 16'h0484;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rst_req = 1'b0, rst_soft = 1'b0;
    logic [15:0] bus_addr = '0;
    logic bus_we = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic bus_hit;
    logic gear_busy = 1'b0, osc_halted = 1'b0, stop_mode = 1'b0;
    logic [1:0] src_sel;
    logic subclk_en, pll_run, prot_err;

    int checks = 0;
    int errors = 0;
    logic [7:0] mreg = 8'h00;
    logic merr = 1'b0;
    logic done = 1'b0;

    always #(CLK_PER/2) clk = ~clk;

    clksrc_guard_reg u0 (
        .clk(clk), .rst_n(rst_n), .rst_req(rst_req), .rst_soft(rst_soft),
        .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_hit(bus_hit), .gear_busy(gear_busy),
        .osc_halted(osc_halted), .stop_mode(stop_mode), .src_sel(src_sel),
        .subclk_en(subclk_en), .pll_run(pll_run), .prot_err(prot_err)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // next register value and error flag from the requirement rules
    function automatic logic [8:0] model_wr(logic [7:0] cur, logic [7:0] w, logic gb);
        logic sub, pll, bad, selbad;
        logic [1:0] sel;
        bad = 1'b0;
        if (cur[1:0] == 2'b11) begin sub = cur[3]; bad = bad | (w[3] != cur[3]); end   // R4
        else sub = w[3];
        if (cur[1:0] == 2'b10 || gb) begin pll = cur[2]; bad = bad | (w[2] != cur[2]); end // R5
        else pll = w[2];
        selbad = (cur[1] && (w[0] != cur[0]))                                            // R6
               || (w[1:0] == 2'b11 && !sub) || (w[1:0] == 2'b10 && !pll);                 // R7
        sel = selbad ? cur[1:0] : w[1:0];
        return {bad | selbad, w[7:4], sub, pll, sel};
    endfunction

    // one bus cycle: inputs already driven after a falling edge
    task automatic step();
        logic [8:0] r;
        #1;
        chk("R1 hit", bus_hit, bus_addr == ADR);
        chk("R1 rdata", bus_rdata, (bus_addr == ADR) ? mreg : 8'h00);
        chk("R8 pll_run", pll_run, mreg[2] && !(osc_halted && stop_mode));
        @(posedge clk);
        merr = 1'b0;
        if (rst_req) begin
            if (!rst_soft) mreg[3:0] = 4'h0;
        end else if (bus_we && bus_addr == ADR) begin
            r = model_wr(mreg, bus_wdata, gear_busy);
            merr = r[8];
            mreg = r[7:0];
        end
        @(negedge clk);
        chk("R9 prot_err", prot_err, merr);
        chk("R8 src_sel", src_sel, mreg[1:0]);
        chk("R8 subclk_en", subclk_en, mreg[3]);
    endtask

    task automatic wr(logic [7:0] d, logic gb);
        bus_addr = ADR; bus_we = 1'b1; bus_wdata = d; gear_busy = gb;
        rst_req = 1'b0;
        step();
        bus_we = 1'b0; gear_busy = 1'b0;
    endtask

    task automatic rd_expect(string req, logic [7:0] exp);
        bus_addr = ADR; bus_we = 1'b0; rst_req = 1'b0;
        #1;
        chk(req, bus_rdata, exp);
    endtask

    initial begin
        #(CLK_PER * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rd_expect("R3 power-on rdata", 8'h00);
        chk("R9 reset prot_err", prot_err, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);

        // directed corner cases
        wr(8'hA5, 1'b0);                 // R2: reserved bits stored; sel 01
        rd_expect("R2 reserved readback", 8'hA5);
        wr(8'h03, 1'b0);                 // R7: sel 11 without sub enable -> reject
        rd_expect("R7 sub needs enable", 8'h01);
        chk("R7 err", prot_err, 1'b1);
        wr(8'h0B, 1'b0);                 // sub enable and sel 11 together: legal
        rd_expect("R7 sub select", 8'h0B);
        wr(8'h03, 1'b0);                 // R4: clearing bit3 while on subclock
        rd_expect("R4 sub frozen", 8'h0B);
        wr(8'h0A, 1'b0);                 // R6: 11 -> 10 changes bit0 while bit1 set
        rd_expect("R6 sel0 held", 8'h0B);
        wr(8'h09, 1'b0);                 // 11 -> 01 legal
        rd_expect("R6 legal exit", 8'h09);
        wr(8'h0E, 1'b1);                 // R5: pll change during gear -> pll kept, sel 10 needs pll
        rd_expect("R5 gear lock", 8'h09);
        wr(8'h0C, 1'b0);                 // pll on, sel 00
        wr(8'h0E, 1'b0);                 // sel 10
        rd_expect("R7 pll select", 8'h0E);
        wr(8'h08, 1'b0);                 // R5: clear pll while on pll; sel -> 00 legal
        rd_expect("R5 pll frozen", 8'h0C);
        osc_halted = 1'b1; stop_mode = 1'b1; #1;
        chk("R8 gated", pll_run, 1'b0);
        stop_mode = 1'b0; #1;
        chk("R8 resumes", pll_run, 1'b1);
        osc_halted = 1'b0;
        wr(8'hFC, 1'b0);
        rst_req = 1'b1; rst_soft = 1'b1; bus_we = 1'b1; bus_wdata = 8'h00;
        step();
        rd_expect("R3 soft hold", 8'hFC);
        rst_req = 1'b1; rst_soft = 1'b0; bus_we = 1'b0;
        step();
        rd_expect("R3 hard clear", 8'hF0);
        rst_req = 1'b0;
        bus_addr = 16'h0485; #1;
        chk("R1 miss", {bus_hit, bus_rdata}, 9'h000);

        // constrained random
        for (int i = 0; i < 4000; i++) begin
            bus_addr   = ($urandom % 4 != 0) ? ADR : 16'($urandom);
            bus_we     = ($urandom % 5) < 3;
            bus_wdata  = 8'($urandom);
            gear_busy  = ($urandom % 5) == 0;
            osc_halted = ($urandom % 3) == 0;
            stop_mode  = ($urandom % 3) == 0;
            rst_req    = ($urandom % 50) == 0;
            rst_soft   = $urandom % 2;
            step();
        end
        rst_req = 1'b0; bus_we = 1'b0;

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule